// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Matrix

A non-blocking routing matrix with 34 single-bit inputs and 34 single-bit outputs. Every output is fed by its own selector that picks exactly one input, and one input may feed any number of outputs at the same time. The data path holds no registers. An input's level reaches the outputs that select it through combinational logic only.

Routes are set through a microprocessor-style parallel port. It has a 6-bit address, a 6-bit bidirectional data bus, and active-low chip-select, write and read strobes, plus an active-high configure input. The address names an output and the data names the input that output should use. A write only loads a per-output staging register. Asserting configure moves every staged selection into the active registers at once, so a group of route changes lands in one step. If configure is held high, each write takes effect as soon as it is staged.

The port strobes, address and data are synchronised to the system clock and edge-detected inside the block. A write therefore reaches the staging register a few clock cycles after the write strobe rises. Read-back returns the active selection of the addressed output.

Top module: `xpt_switch`

## Requirements
- R1: Each output `dout[o]` equals `din[s]`, where s is the active selection of output o. The same input can drive several outputs at the same time.
- R2: On a write, the address is the output number in plain binary and the data bus value is the input number. For example, address 4 with data 6 routes input 6 to output 4.
- R3: A selection is staged only on a rising edge of `wr_n` while `cs_n` is low. A write strobe given with `cs_n` high changes nothing.
- R4: A staged selection has no effect on `dout` until a configure step copies it to the active registers.
- R5: While `cfg` is high and `cs_n` is low, all staged selections are copied to the active registers together. They take effect on the outputs within 4 clock cycles.
- R6: With `cfg` held high and `cs_n` low, a write changes the output within 6 clock cycles of the `wr_n` rising edge, with no separate configure pulse.
- R7: With `cs_n` and `rd_n` low and the address of an output (00h to 21h) applied, the data bus shows that output's active selection within 5 clock cycles.
- R8: The block drives the data bus only during a read with `cs_n` low. At all other times the bus is left to other drivers.
- R9: Writes to addresses 22h through 3Fh change no selection.
- R10: Synchronous reset (`rst` high) sets every staged and active selection to input 0.
- R11: An active selection of 34 or more routes input 0 to that output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for the port logic |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low; its rising edge stages data |
| rd_n | input | 1 | Read strobe, active low |
| cfg | input | 1 | Configure: copies staged selections to active ones |
| addr | input | 6 | Output number to access |
| data | inout | 6 | Input number written or read back |
| din | input | 34 | Switch inputs |
| dout | output | 34 | Switch outputs |

## Verification
The assertions assume that the address and data stay steady for the whole time a strobe is low, and for several cycles after it rises, so that the synchronised bus and strobes line up. They also assume that each strobe level lasts at least three clock cycles, and that a read and a write are never requested together. The bench holds to these rules: it changes inputs only on falling clock edges and uses tasks that put three to six cycles between each step of a transaction. It also releases its own bus driver before any read.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
   localparam int XPT_SYNC_STAGES = 2;

   typedef struct packed {
      logic cs_n;
      logic wr_n;
      logic rd_n;
      logic cfg;
   } xpt_strobe_t;

   localparam xpt_strobe_t XPT_STROBE_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, cfg: 1'b0};
endpackage

// File: rtl/xpt_port_sync.sv
module xpt_port_sync #(
   parameter int          W       = 4,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xpt_port_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      end else begin
         pipe[0] <= d_in;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/xpt_cfg_regs.sv
module xpt_cfg_regs #(
   parameter int N_OUT = 34,
   parameter int AW    = 6,
   parameter int DW    = 6
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_hit,
   input  logic [AW-1:0]         wr_addr,
   input  logic [DW-1:0]         wr_data,
   input  logic                  commit,
   output logic [N_OUT*DW-1:0]   stage_flat,
   output logic [N_OUT*DW-1:0]   active_flat
);
   localparam int FLAT_W = N_OUT * DW;

   generate
      if (N_OUT > (1 << AW)) begin : g_bad_aw
         $error("xpt_cfg_regs: AW too narrow for N_OUT");
      end
   endgenerate

   genvar o;
   generate
      for (o = 0; o < N_OUT; o++) begin : g_slot
         logic [DW-1:0] stg_q;
         logic [DW-1:0] act_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               stg_q <= '0;
            end else if (wr_hit && (wr_addr == AW'(o))) begin
               stg_q <= wr_data;
            end
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               act_q <= '0;
            end else if (commit) begin
               act_q <= stg_q;
            end
         end

         assign stage_flat[o*DW +: DW]  = stg_q;
         assign active_flat[o*DW +: DW] = act_q;
      end
   endgenerate

   AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !wr_hit |=> $stable(stage_flat)) else $error("staging changed without write"); // R3

   AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (wr_hit && (int'(wr_addr) >= N_OUT)) |=> $stable(stage_flat)) else $error("high address write landed"); // R9

   AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !commit |=> $stable(active_flat)) else $error("active changed without commit"); // R4

   AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (rst)
      commit |=> (active_flat == $past(stage_flat))) else $error("commit did not copy staging"); // R5

   AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> ((active_flat == FLAT_W'(0)) && (stage_flat == FLAT_W'(0)))) else $error("reset state not input 0"); // R10
endmodule

// File: rtl/xpt_route.sv
module xpt_route #(
   parameter int N_IN  = 34,
   parameter int N_OUT = 34,
   parameter int DW    = 6
) (
   input  logic [N_IN-1:0]       din,
   input  logic [N_OUT*DW-1:0]   active_flat,
   output logic [N_OUT-1:0]      dout
);
   generate
      if (N_IN > (1 << DW)) begin : g_bad_dw
         $error("xpt_route: DW too narrow for N_IN");
      end
   endgenerate

   genvar o;
   generate
      for (o = 0; o < N_OUT; o++) begin : g_mux
         logic [DW-1:0] sel;
         logic          pick;

         assign sel = active_flat[o*DW +: DW];

         always_comb begin
            pick = din[0];
            for (int i = 1; i < N_IN; i++) begin
               if (sel == DW'(i)) pick = din[i];
            end
         end

         assign dout[o] = pick;

         always_comb begin
            if (int'(sel) >= N_IN) begin
               AST_OOR_INPUT0: assert (dout[o] == din[0]) else $error("out-of-range select not input 0"); // R11
            end
         end
      end
   endgenerate
endmodule

// File: rtl/xpt_switch.sv
module xpt_switch #(
   parameter int N_IN  = 34,
   parameter int N_OUT = 34,
   parameter int AW    = 6,
   parameter int DW    = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cs_n,
   input  logic             wr_n,
   input  logic             rd_n,
   input  logic             cfg,
   input  logic [AW-1:0]    addr,
   inout  wire  [DW-1:0]    data,
   input  logic [N_IN-1:0]  din,
   output logic [N_OUT-1:0] dout
);
   import xpt_pkg::*;

   localparam int BUS_W  = AW + DW;
   localparam int FLAT_W = N_OUT * DW;

   xpt_strobe_t  strobe_raw, strobe_s;
   logic [BUS_W-1:0] bus_s;
   logic [AW-1:0]    addr_s;
   logic [DW-1:0]    data_s;

   assign strobe_raw = '{cs_n: cs_n, wr_n: wr_n, rd_n: rd_n, cfg: cfg};

   xpt_port_sync #(.W($bits(xpt_strobe_t)), .STAGES(XPT_SYNC_STAGES),
                   .RST_VAL(XPT_STROBE_IDLE)) u_strobe_sync (
      .clk(clk), .rst(rst), .d_in(strobe_raw), .d_out(strobe_s)
   );

   xpt_port_sync #(.W(BUS_W), .STAGES(XPT_SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
      .clk(clk), .rst(rst), .d_in({addr, data}), .d_out(bus_s)
   );

   assign addr_s = bus_s[BUS_W-1:DW];
   assign data_s = bus_s[DW-1:0];

   logic wr_prev;
   always_ff @(posedge clk) begin
      if (rst) wr_prev <= 1'b1;
      else     wr_prev <= strobe_s.wr_n;
   end

   logic wr_hit, commit;
   assign wr_hit = strobe_s.wr_n & ~wr_prev & ~strobe_s.cs_n;
   assign commit = strobe_s.cfg & ~strobe_s.cs_n;

   logic [FLAT_W-1:0] stage_flat, active_flat;

   xpt_cfg_regs #(.N_OUT(N_OUT), .AW(AW), .DW(DW)) u_regs (
      .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_addr(addr_s), .wr_data(data_s),
      .commit(commit), .stage_flat(stage_flat), .active_flat(active_flat)
   );

   xpt_route #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW)) u_route (
      .din(din), .active_flat(active_flat), .dout(dout)
   );

   logic [DW-1:0] rd_q;
   logic          oe_q;
   logic [DW-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      for (int o = 0; o < N_OUT; o++) begin
         if (addr_s == AW'(o)) rd_next = active_flat[o*DW +: DW];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q <= '0;
         oe_q <= 1'b0;
      end else begin
         rd_q <= rd_next;
         oe_q <= ~strobe_s.cs_n & ~strobe_s.rd_n;
      end
   end

   assign data = oe_q ? rd_q : {DW{1'bz}};

   AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
      strobe_s.cs_n |=> !oe_q) else $error("bus driven without chip select"); // R8

   AST_NO_WRITE_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
      strobe_s.cs_n |=> $stable(stage_flat)) else $error("staging changed while deselected"); // R3
endmodule

// File: tb/sim_xpt_switch.sv
module sim_xpt_switch;
   localparam int NI = 34;
   localparam int NO = 34;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, cfg = 1'b0;
   logic [5:0] addr = '0;
   logic [5:0] tb_dat = '0;
   logic tb_oe = 1'b0;
   wire  [5:0] data;
   logic [NI-1:0] din = '0;
   logic [NO-1:0] dout;

   assign data = tb_oe ? tb_dat : 6'bzzzzzz;

   always #2 clk = ~clk;

   xpt_switch u0 (
      .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .cfg(cfg),
      .addr(addr), .data(data), .din(din), .dout(dout)
   );

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;
   int exp_sel [NO];

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [NO-1:0] model(input logic [NI-1:0] pat);
      logic [NO-1:0] r;
      for (int o = 0; o < NO; o++) r[o] = (exp_sel[o] < NI) ? pat[exp_sel[o]] : pat[0];
      return r;
   endfunction

   task automatic check_out(input string req, input logic [NI-1:0] pat);
      @(negedge clk);
      din = pat;
      idle(1);
      compared++;
      if (dout !== model(pat)) begin
         mismatched++;
         $display("FAIL %s dout act=%h exp=%h (din=%h)", req, dout, model(pat), pat);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [5:0] d, input logic sel_n, input logic cf);
      @(negedge clk);
      addr = a; tb_dat = d; tb_oe = 1'b1; cs_n = sel_n; cfg = cf;
      idle(3); wr_n = 1'b0;
      idle(3); wr_n = 1'b1;
      idle(6); cs_n = 1'b1; cfg = 1'b0;
      idle(1); tb_oe = 1'b0;
      idle(3);
   endtask

   task automatic commit_all();
      @(negedge clk);
      cs_n = 1'b0; cfg = 1'b1;
      idle(4); cfg = 1'b0;
      idle(3); cs_n = 1'b1;
      idle(3);
   endtask

   task automatic rd_check(input string req, input logic [5:0] a, input logic [5:0] exp);
      @(negedge clk);
      tb_oe = 1'b0; addr = a; cs_n = 1'b0; rd_n = 1'b0;
      idle(6);
      compared++;
      if (data !== exp) begin
         mismatched++;
         $display("FAIL %s readback addr=%0d act=%0d exp=%0d", req, a, data, exp);
      end
      rd_n = 1'b1; cs_n = 1'b1;
      idle(4);
   endtask

   initial begin
      for (int o = 0; o < NO; o++) exp_sel[o] = 0;
      idle(5); rst = 1'b0; idle(4);

      // R10: reset routes every output to input 0
      check_out("R10", 34'h1);
      check_out("R10", 34'h3_FFFF_FFFE);
      rd_check("R10", 6'd5, 6'd0);

      // R4: staging alone must not move outputs
      for (int o = 0; o < NO; o++) wr(6'(o), 6'((o * 7 + 3) % NI), 1'b0, 1'b0);
      check_out("R4", 34'h1);
      check_out("R4", 34'h2AAAA_AAAA);

      // R5 R2 R1: commit, then walking-one sweep
      commit_all();
      for (int o = 0; o < NO; o++) exp_sel[o] = (o * 7 + 3) % NI;
      for (int i = 0; i < NI; i++) check_out("R1/R5", 34'(1) << i);
      check_out("R2", 34'h3_FFFF_FFFF);
      check_out("R2", 34'h1_2345_6789);

      // R7: read back every active selection
      for (int o = 0; o < NO; o++) rd_check("R7", 6'(o), 6'(exp_sel[o]));

      // R9: high addresses are ignored
      wr(6'd34, 6'd9, 1'b0, 1'b0);
      wr(6'd40, 6'd9, 1'b0, 1'b0);
      wr(6'd63, 6'd9, 1'b0, 1'b0);
      commit_all();
      check_out("R9", 34'h2_5A5A_5A5A);
      for (int o = 0; o < NO; o += 11) rd_check("R9", 6'(o), 6'(exp_sel[o]));

      // R3: write strobe with chip select high is ignored
      wr(6'd0, 6'd1, 1'b1, 1'b0);
      commit_all();
      rd_check("R3", 6'd0, 6'(exp_sel[0]));
      check_out("R3", 34'h1_0F0F_0F0F);

      // R11: out-of-range selection routes input 0
      wr(6'd3, 6'd50, 1'b0, 1'b0);
      commit_all();
      exp_sel[3] = 50;
      check_out("R11", 34'h1);
      check_out("R11", 34'h3_FFFF_FFFE);

      // R1: fan-out of one input to three outputs
      wr(6'd10, 6'd20, 1'b0, 1'b0);
      wr(6'd11, 6'd20, 1'b0, 1'b0);
      wr(6'd12, 6'd20, 1'b0, 1'b0);
      commit_all();
      exp_sel[10] = 20; exp_sel[11] = 20; exp_sel[12] = 20;
      check_out("R1", 34'(1) << 20);
      check_out("R1", ~(34'(1) << 20));

      // R6: configure held high makes writes immediate
      wr(6'd7, 6'd33, 1'b0, 1'b1);
      exp_sel[7] = 33;
      check_out("R6", 34'(1) << 33);
      check_out("R6", 34'h1_FFFF_FFFF);

      // R8: no drive from the block while not selected
      @(negedge clk);
      tb_oe = 1'b1; tb_dat = 6'h15; addr = 6'd7; rd_n = 1'b0; cs_n = 1'b1;
      idle(6);
      compared++;
      if (data !== 6'h15) begin
         mismatched++;
         $display("FAIL R8 bus act=%h exp=%h", data, 6'h15);
      end
      rd_n = 1'b1; tb_oe = 1'b0;
      idle(4);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule